// File: doc/BRIEF.md
# Synchronized Clock Stop and Power-Down Controller

This block gates four groups of derived clocks for power management: the processor clocks, the stoppable bus clocks, one free-running bus clock, and a group of auxiliary clocks (reference, serial-bus and interrupt-controller rates). Three asynchronous active-low requests come in: stop the processor clocks, stop the bus clocks, and power down. Each request passes through a two-flop synchronizer. Each group's gate enable is a register that may change only while that group's source is low. An output therefore starts and stops only on whole cycles and always parks low.

A small power-management state machine sequences full power-down and the return from it. It has four states:
- `PM_RUN`: the gates follow the stop requests.
- `PM_PARK`: every gate is closed.
- `PM_OFF`: the oscillator/PLL enable `osc_en` is dropped.
- `PM_SETTLE`: `osc_en` is high again, but the gates stay closed for a programmable number of reference ticks that models the PLL lock wait.

The transitions are:
- RUN→PARK when power-down is requested.
- PARK→OFF once all gates are closed and one rising edge of the reference source has followed.
- OFF→SETTLE when the request is withdrawn.
- SETTLE→RUN after `SETTLE_TICKS` reference rising edges.
- SETTLE→PARK if power-down returns during the lock wait.

Reset enters `PM_SETTLE`. The clock sources are inputs that are sampled on the system clock `clk`; generating them is outside this block.

Top module: `clkstop_ctrl`

## Requirements
- R1: After reset all clock outputs are low and `osc_en` is high, and no output pulses before `SETTLE_TICKS` reference rising edges have been seen.
- R2: With `pwr_dwn_n` high, `cpu_stop_n` low parks every `cpu_clk` bit low; with it high, `cpu_clk` follows `cpu_src`.
- R3: With `pwr_dwn_n` high, `pci_stop_n` low parks every `pci_clk` bit low while `pci_free_clk` keeps following `pci_src`; with it high, `pci_clk` follows `pci_src`.
- R4: With `pwr_dwn_n` high, `pci_free_clk` and `oth_clk` run whatever the values of `cpu_stop_n` and `pci_stop_n`.
- R5: With `pwr_dwn_n` low, every output goes low, the free-running and auxiliary outputs included, and `osc_en` then goes low.
- R6: `osc_en` falls only after all outputs are parked low and at least one further rising edge of `ref_src` has followed.
- R7: After `pwr_dwn_n` returns high, `osc_en` rises first. The outputs stay low until `SETTLE_TICKS` rising edges of `ref_src` have occurred with `osc_en` high, and then the groups resume as their stop inputs allow.
- R8: Every high phase of an output is a complete high phase of its source, and all bits of one group are equal. A gate enable changes only on a clock edge where its source was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Asynchronous request, low stops processor clocks |
| pci_stop_n | input | 1 | Asynchronous request, low stops stoppable bus clocks |
| pwr_dwn_n | input | 1 | Asynchronous request, low powers everything down |
| cpu_src | input | 1 | Processor clock source |
| pci_src | input | 1 | Bus clock source (stoppable and free-running) |
| ref_src | input | 1 | Auxiliary/reference clock source, also the slow tick |
| cpu_clk | output | NCPU | Gated processor clocks |
| pci_clk | output | NPCI | Gated stoppable bus clocks |
| pci_free_clk | output | 1 | Free-running bus clock |
| oth_clk | output | NOTH | Gated auxiliary clocks |
| osc_en | output | 1 | Oscillator/PLL enable |

## Verification
The bench steps through the stop patterns one at a time:
- both stops released;
- only the processor stop asserted;
- both stops asserted;
- only the bus stop asserted;
- power-down with the processor stop asserted.

Each pattern separates one group's gating from the others. Above all it separates the stoppable bus outputs from the free-running one, which shares their source.

On every clock a behavioural monitor tracks each source's high phases and flags any output high phase that is not whole. Across power-down entry and exit it counts reference edges, which checks that the enable falls only after the outputs are parked and that the lock wait lasts long enough. The three sources run at different ratios, so stopping at a wrong phase on any of them would show up as a shortened pulse.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;
    typedef enum logic [1:0] {
        PM_RUN    = 2'd0,
        PM_PARK   = 2'd1,
        PM_OFF    = 2'd2,
        PM_SETTLE = 2'd3
    } pm_state_t;

    localparam int unsigned NGROUP   = 4;
    localparam int unsigned GRP_CPU  = 0;
    localparam int unsigned GRP_PCI  = 1;
    localparam int unsigned GRP_FREE = 2;
    localparam int unsigned GRP_OTH  = 3;
endpackage

// File: rtl/clkstop_sync.sv
module clkstop_sync #(
    parameter int unsigned W       = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         src,
    input  logic         allow,
    output logic         en,
    output logic [W-1:0] clk_out
);
    logic en_q;

    // Enable may move only while the source is low: no phase is cut short.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   en_q <= 1'b0;
        else if (!src) en_q <= allow;
    end

    assign en      = en_q;
    assign clk_out = {W{src & en_q}};
endmodule

// File: rtl/clkstop_pm_fsm.sv
module clkstop_pm_fsm
    import clkstop_pkg::*;
#(
    parameter int unsigned SETTLE_TICKS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_ok,
    input  logic              cpu_run,
    input  logic              pci_run,
    input  logic              ref_tick,
    input  logic              gates_idle,
    output logic [NGROUP-1:0] allow,
    output logic              osc_en
);
    localparam int unsigned CW   = $clog2(SETTLE_TICKS) + 1;
    localparam logic [CW-1:0] LAST = CW'(SETTLE_TICKS - 1);

    pm_state_t     state, nxt;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PM_SETTLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (state != PM_SETTLE) cnt <= '0;
        else if (ref_tick)           cnt <= cnt + 1'b1;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            PM_RUN:    if (!pwr_ok) nxt = PM_PARK;
            PM_PARK:   if (gates_idle && ref_tick) nxt = PM_OFF;
            PM_OFF:    if (pwr_ok) nxt = PM_SETTLE;
            PM_SETTLE: begin
                if (!pwr_ok)                      nxt = PM_PARK;
                else if (ref_tick && cnt == LAST) nxt = PM_RUN;
            end
            default:   nxt = PM_PARK;
        endcase
    end

    always_comb begin
        allow  = '0;
        osc_en = 1'b1;
        unique case (state)
            PM_RUN: begin
                allow[GRP_CPU]  = cpu_run;
                allow[GRP_PCI]  = pci_run;
                allow[GRP_FREE] = 1'b1;
                allow[GRP_OTH]  = 1'b1;
            end
            PM_PARK:   osc_en = 1'b1;
            PM_OFF:    osc_en = 1'b0;
            PM_SETTLE: osc_en = 1'b1;
            default:   osc_en = 1'b1;
        endcase
    end
endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl
    import clkstop_pkg::*;
#(
    parameter int unsigned NCPU         = 4,
    parameter int unsigned NPCI         = 7,
    parameter int unsigned NOTH         = 7,
    parameter int unsigned SETTLE_TICKS = 4,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cpu_stop_n,
    input  logic            pci_stop_n,
    input  logic            pwr_dwn_n,
    input  logic            cpu_src,
    input  logic            pci_src,
    input  logic            ref_src,
    output logic [NCPU-1:0] cpu_clk,
    output logic [NPCI-1:0] pci_clk,
    output logic            pci_free_clk,
    output logic [NOTH-1:0] oth_clk,
    output logic            osc_en
);
    logic [2:0]        req_s;
    logic [NGROUP-1:0] allow;
    logic [NGROUP-1:0] gate_en;
    logic              ref_q;
    logic              ref_tick;

    clkstop_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({pwr_dwn_n, pci_stop_n, cpu_stop_n}),
        .q(req_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_q <= 1'b0;
        else        ref_q <= ref_src;
    end
    assign ref_tick = ref_src & ~ref_q;

    clkstop_pm_fsm #(.SETTLE_TICKS(SETTLE_TICKS)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .pwr_ok(req_s[2]), .cpu_run(req_s[0]), .pci_run(req_s[1]),
        .ref_tick(ref_tick), .gates_idle(gate_en == '0),
        .allow(allow), .osc_en(osc_en)
    );

    clkstop_gate #(.W(NCPU)) u_gate_cpu (
        .clk(clk), .rst_n(rst_n), .src(cpu_src), .allow(allow[GRP_CPU]),
        .en(gate_en[GRP_CPU]), .clk_out(cpu_clk)
    );
    clkstop_gate #(.W(NPCI)) u_gate_pci (
        .clk(clk), .rst_n(rst_n), .src(pci_src), .allow(allow[GRP_PCI]),
        .en(gate_en[GRP_PCI]), .clk_out(pci_clk)
    );
    clkstop_gate #(.W(1)) u_gate_free (
        .clk(clk), .rst_n(rst_n), .src(pci_src), .allow(allow[GRP_FREE]),
        .en(gate_en[GRP_FREE]), .clk_out(pci_free_clk)
    );
    clkstop_gate #(.W(NOTH)) u_gate_oth (
        .clk(clk), .rst_n(rst_n), .src(ref_src), .allow(allow[GRP_OTH]),
        .en(gate_en[GRP_OTH]), .clk_out(oth_clk)
    );
endmodule

// File: rtl/clkstop_ctrl_chk.sv
module clkstop_ctrl_chk
    import clkstop_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NGROUP-1:0] src,
    input logic [NGROUP-1:0] en,
    input logic [NGROUP-1:0] allow,
    input logic              osc_en
);
    for (genvar g = 0; g < NGROUP; g++) begin : g_grp
        // R8: enable moves only on an edge where the source was low
        a_r8_en_moves_low: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(en[g]) |-> !$past(src[g]));
        // R2 and R3: a gate opens only when the sequencer allowed it
        a_r2_open_needs_allow: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(en[g]) |-> $past(allow[g]));
        a_r3_close_needs_deny: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(en[g]) |-> !$past(allow[g]));
    end

    a_r6_off_after_park: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en) |-> $past(en == '0));

    a_r5_off_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |-> en == '0);

    a_r7_wake_closed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(osc_en) |-> en == '0);
endmodule

bind clkstop_ctrl clkstop_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .src({ref_src, pci_src, pci_src, cpu_src}),
    .en(gate_en), .allow(allow), .osc_en(osc_en)
);

// File: tb/clkstop_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkstop_ctrl_tb_top;
    localparam int NCPU = 4, NPCI = 7, NOTH = 7, SETTLE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwr_dwn_n = 1'b1;
    logic cpu_src = 1'b0, pci_src = 1'b0, ref_src = 1'b0;
    logic [NCPU-1:0] cpu_clk;
    logic [NPCI-1:0] pci_clk;
    logic [NOTH-1:0] oth_clk;
    logic pci_free_clk, osc_en;

    int checks = 0, fails = 0;
    bit done = 0, mon_on = 0;

    clkstop_ctrl #(.NCPU(NCPU), .NPCI(NPCI), .NOTH(NOTH), .SETTLE_TICKS(SETTLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n),
        .pwr_dwn_n(pwr_dwn_n), .cpu_src(cpu_src), .pci_src(pci_src), .ref_src(ref_src),
        .cpu_clk(cpu_clk), .pci_clk(pci_clk), .pci_free_clk(pci_free_clk),
        .oth_clk(oth_clk), .osc_en(osc_en)
    );

    always #2 clk = ~clk;

    // Sources: ratios 2, 6 and 14 system clocks, changed on the falling edge.
    int pdiv = 0, rdiv = 0;
    always @(negedge clk) begin
        cpu_src <= ~cpu_src;
        pdiv = pdiv + 1;
        if (pdiv == 3) begin pdiv = 0; pci_src <= ~pci_src; end
        rdiv = rdiv + 1;
        if (rdiv == 7) begin rdiv = 0; ref_src <= ~ref_src; end
    end

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Behavioural monitor state
    bit  prev_src [4];
    bit  phase_v  [4];
    bit  prev_out [4];
    int  rises    [4];
    bit  prev_ref = 0, prev_osc = 1, prev_any = 0;
    int  settle_cnt = 0, ref_quiet = 0;
    bit  settle_on = 1;

    function automatic bit src_of(int g);
        case (g)
            0: return cpu_src;
            1: return pci_src;
            2: return pci_src;
            default: return ref_src;
        endcase
    endfunction

    function automatic bit out_of(int g);
        case (g)
            0: return |cpu_clk;
            1: return |pci_clk;
            2: return pci_free_clk;
            default: return |oth_clk;
        endcase
    endfunction

    always @(posedge clk) begin
        #1;
        if (mon_on) begin
            bit any, ref_rise;
            any = |cpu_clk | |pci_clk | pci_free_clk | |oth_clk;
            ref_rise = ref_src && !prev_ref;
            // R8: whole high phases only, group bits equal
            for (int g = 0; g < 4; g++) begin
                bit s, o;
                s = src_of(g);
                o = out_of(g);
                if (s && !prev_src[g]) phase_v[g] = o;
                else if (s && o != phase_v[g]) chk("R8 partial phase", o, phase_v[g]);
                if (o && !prev_out[g]) rises[g]++;
                prev_src[g] = s;
                prev_out[g] = o;
            end
            if (!(cpu_clk == '0 || cpu_clk == '1)) chk("R8 cpu bits", 1, 0);
            if (!(pci_clk == '0 || pci_clk == '1)) chk("R8 pci bits", 1, 0);
            if (!(oth_clk == '0 || oth_clk == '1)) chk("R8 oth bits", 1, 0);
            // R7: lock wait counted in reference edges with osc_en high
            if (osc_en && !prev_osc) begin settle_on = 1; settle_cnt = 0; end
            if (settle_on && osc_en && ref_rise) settle_cnt++;
            if (settle_on && any && settle_cnt < SETTLE) chk("R7 early output", settle_cnt, SETTLE);
            if (settle_cnt >= SETTLE) settle_on = 0;
            // R6: enable drop only after parking plus one reference edge
            if (any) ref_quiet = 0;
            else if (ref_rise) ref_quiet++;
            if (!osc_en && prev_osc) begin
                chk("R6 outputs parked at drop", any | prev_any, 0);
                chk("R6 ref edge before drop", ref_quiet >= 1, 1);
            end
            prev_ref = ref_src;
            prev_osc = osc_en;
            prev_any = any;
        end
    end

    task automatic expect_run(string req, int g, bit exp);
        for (int i = 0; i < 4; i++) rises[i] = 0;
        repeat (40) @(posedge clk);
        #2;
        chk(req, rises[g] > 0, exp);
    endtask

    task automatic settle(int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin
            prev_src[i] = 0; phase_v[i] = 0; prev_out[i] = 0; rises[i] = 0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        mon_on = 1;
        @(posedge clk); #2;
        chk("R1 cpu low after reset", cpu_clk, 0);
        chk("R1 pci low after reset", pci_clk, 0);
        chk("R1 free low after reset", pci_free_clk, 0);
        chk("R1 oth low after reset", oth_clk, 0);
        chk("R1 osc_en high after reset", osc_en, 1);
        settle(150);

        expect_run("R2 cpu runs", 0, 1);
        expect_run("R3 pci runs", 1, 1);
        expect_run("R4 free runs", 2, 1);
        expect_run("R4 oth runs", 3, 1);

        cpu_stop_n = 1'b0; settle(20);
        expect_run("R2 cpu stopped", 0, 0);
        expect_run("R3 pci runs with cpu stop", 1, 1);
        expect_run("R4 free runs with cpu stop", 2, 1);

        pci_stop_n = 1'b0; settle(20);
        expect_run("R3 pci stopped", 1, 0);
        expect_run("R3 free still runs", 2, 1);
        expect_run("R4 oth runs with both stops", 3, 1);

        cpu_stop_n = 1'b1; settle(20);
        expect_run("R2 cpu restarts", 0, 1);
        expect_run("R3 pci stays stopped", 1, 0);

        pci_stop_n = 1'b1; settle(20);
        expect_run("R3 pci restarts", 1, 1);

        cpu_stop_n = 1'b0;
        pwr_dwn_n = 1'b0; settle(60);
        chk("R5 osc_en low", osc_en, 0);
        expect_run("R5 free stopped", 2, 0);
        expect_run("R5 oth stopped", 3, 0);
        expect_run("R5 pci stopped", 1, 0);

        cpu_stop_n = 1'b1;
        pwr_dwn_n = 1'b1; settle(10);
        chk("R7 osc_en back", osc_en, 1);
        settle(120);
        expect_run("R7 cpu resumes", 0, 1);
        expect_run("R7 oth resumes", 3, 1);
        expect_run("R7 free resumes", 2, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule